// File: doc/BRIEF.md
# Byte-Dirty-Tagged Block Buffer

This block is a small write-back store sitting between a pixel arithmetic unit and a slower backing memory. It holds a fixed number of blocks, each made of several 32-bit words. Alongside every block it keeps a tag with one bit per byte. A tag bit is set when the arithmetic unit has changed that byte since the block last arrived from backing memory.

Backing memory fills a whole block in one cycle through the load port, and that load clears the block's tag. The arithmetic unit writes single words with per-byte enables. It can also read single words back, one cycle after presenting the address. When a block is to be retired, the write-back port delivers the full block and its byte mask together. Backing memory can then merge only the modified bytes. A done pulse clears the tag afterwards.

Top module: `dirty_block_buf`

## Requirements
- R1: A synchronous active-high reset clears every byte tag to zero and drives `wb_valid` and `collide` low. Data contents are not reset.
- R2: A load (`ld_en`) overwrites all bits of block `ld_blk`, with word w taken from `ld_data[32w+31:32w]`, and sets that block's tag to zero.
- R3: A word write (`wr_en`) changes only the bytes whose enable is 1. Enable bit k selects bits [8k+7:8k] of word `wr_word` in block `wr_blk`, and the other bytes keep their value.
- R4: A word write ORs its byte enables into the tag, so that enable bit k of word w sets tag bit 4w+k. Tag bits already set stay set.
- R5: A word read presented with `rd_en` returns `rd_data` on the next cycle. If a write or load to that word happens in the same cycle, the read returns the value from before that cycle.
- R6: A write-back request (`wb_req`) makes `wb_valid` high on the next cycle, and only then. On that cycle `wb_data` holds the whole block and `wb_mask` holds its tag, both as they stood before the request cycle's updates.
- R7: `wb_done` clears the tag of block `wb_done_blk`. A write to the same block in the same cycle still sets its own tag bits.
- R8: A load and a write to the same block in the same cycle apply the load only. The write changes neither data nor tag, and `collide` is high on the following cycle only.
- R9: A load and a write to different blocks in the same cycle both take effect, and `collide` stays low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Block load from backing memory |
| ld_blk | input | 3 | Block index for the load |
| ld_data | input | 256 | Full block contents for the load |
| wr_en | input | 1 | Word write from the arithmetic unit |
| wr_blk | input | 3 | Block index for the write |
| wr_word | input | 3 | Word index within the block for the write |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Word write data |
| rd_en | input | 1 | Word read request |
| rd_blk | input | 3 | Block index for the read |
| rd_word | input | 3 | Word index for the read |
| rd_data | output | 32 | Read data, one cycle after the request |
| wb_req | input | 1 | Write-back request |
| wb_blk | input | 3 | Block index for the write-back |
| wb_valid | output | 1 | Write-back outputs are valid |
| wb_data | output | 256 | Block contents being written back |
| wb_mask | output | 32 | Byte dirty mask of the block being written back |
| wb_done | input | 1 | Write-back complete, clear the tag |
| wb_done_blk | input | 3 | Block whose tag is cleared |
| collide | output | 1 | Load and write hit the same block in the previous cycle |

## Verification
The bench builds the block with its default parameters: eight blocks of eight 32-bit words, so the tags are 32 bits. With only eight blocks and eight words, random traffic often puts a load and a write on the same block in one cycle. It also often lands a done pulse on a block being written, and reads a word in the same cycle it is written, so collisions and read-first ordering come up often. The narrow indices also place the top word, whose tag bits sit in positions 31:28, within easy reach of the directed cases.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  localparam int BYTE_W      = 8;
  localparam int DEF_NUM_BLK = 8;
  localparam int DEF_WORDS   = 8;
  localparam int DEF_WORD_W  = 32;
endpackage

// File: rtl/dbb_store.sv
module dbb_store #(
  parameter int NUM_BLK = dbb_pkg::DEF_NUM_BLK,
  parameter int WORDS   = dbb_pkg::DEF_WORDS,
  parameter int WORD_W  = dbb_pkg::DEF_WORD_W,
  localparam int BLK_AW  = $clog2(NUM_BLK),
  localparam int WORD_AW = $clog2(WORDS),
  localparam int BE_W    = WORD_W / dbb_pkg::BYTE_W,
  localparam int BLK_W   = WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               ld_en,
  input  logic [BLK_AW-1:0]  ld_blk,
  input  logic [BLK_W-1:0]   ld_data,
  input  logic               wr_en,
  input  logic [BLK_AW-1:0]  wr_blk,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [BLK_AW-1:0]  rd_blk,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               wb_req,
  input  logic [BLK_AW-1:0]  wb_blk,
  output logic [BLK_W-1:0]   wb_data
);
  localparam int BW = dbb_pkg::BYTE_W;

  logic [WORD_W-1:0] mem [NUM_BLK][WORDS];

  // load port has the whole block; ALU port touches one word by bytes
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLK; b++) begin
      for (int w = 0; w < WORDS; w++) begin
        for (int k = 0; k < BE_W; k++) begin
          if (ld_en && ld_blk == BLK_AW'(b))
            mem[b][w][k*BW +: BW] <= ld_data[w*WORD_W + k*BW +: BW];
          else if (wr_en && wr_blk == BLK_AW'(b) &&
                   wr_word == WORD_AW'(w) && wr_be[k])
            mem[b][w][k*BW +: BW] <= wr_data[k*BW +: BW];
        end
      end
    end
  end

  // read-first registered reads
  always_ff @(posedge clk) begin
    if (rd_en)
      rd_data <= mem[rd_blk][rd_word];
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_wb
      always_ff @(posedge clk) begin
        if (wb_req)
          wb_data[w*WORD_W +: WORD_W] <= mem[wb_blk][w];
      end
    end
  endgenerate
endmodule

// File: rtl/dbb_tags.sv
module dbb_tags #(
  parameter int NUM_BLK = dbb_pkg::DEF_NUM_BLK,
  parameter int TAG_W   = 32,
  localparam int BLK_AW = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [BLK_AW-1:0] ld_blk,
  input  logic              set_en,
  input  logic [BLK_AW-1:0] set_blk,
  input  logic [TAG_W-1:0]  set_bits,
  input  logic              clr_en,
  input  logic [BLK_AW-1:0] clr_blk,
  input  logic              rd_en,
  input  logic [BLK_AW-1:0] rd_blk,
  output logic [TAG_W-1:0]  rd_mask
);
  logic [TAG_W-1:0] tag_q [NUM_BLK];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BLK; b++) begin
      if (rst)
        tag_q[b] <= '0;
      else if (ld_en && ld_blk == BLK_AW'(b))
        tag_q[b] <= '0;
      else
        tag_q[b] <= ((clr_en && clr_blk == BLK_AW'(b)) ? '0 : tag_q[b]) |
                    ((set_en && set_blk == BLK_AW'(b)) ? set_bits : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_mask <= '0;
    else if (rd_en)
      rd_mask <= tag_q[rd_blk];
  end
endmodule

// File: rtl/dirty_block_buf.sv
module dirty_block_buf #(
  parameter int NUM_BLK = dbb_pkg::DEF_NUM_BLK,
  parameter int WORDS   = dbb_pkg::DEF_WORDS,
  parameter int WORD_W  = dbb_pkg::DEF_WORD_W,
  localparam int BLK_AW  = $clog2(NUM_BLK),
  localparam int WORD_AW = $clog2(WORDS),
  localparam int BE_W    = WORD_W / dbb_pkg::BYTE_W,
  localparam int BLK_W   = WORDS * WORD_W,
  localparam int TAG_W   = WORDS * BE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [BLK_AW-1:0]  ld_blk,
  input  logic [BLK_W-1:0]   ld_data,
  input  logic               wr_en,
  input  logic [BLK_AW-1:0]  wr_blk,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [BLK_AW-1:0]  rd_blk,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               wb_req,
  input  logic [BLK_AW-1:0]  wb_blk,
  output logic               wb_valid,
  output logic [BLK_W-1:0]   wb_data,
  output logic [TAG_W-1:0]   wb_mask,
  input  logic               wb_done,
  input  logic [BLK_AW-1:0]  wb_done_blk,
  output logic               collide
);
  logic             hit_same;
  logic             wr_ok;
  logic [TAG_W-1:0] wr_bits;

  assign hit_same = ld_en && wr_en && (ld_blk == wr_blk);
  assign wr_ok    = wr_en && !hit_same;
  assign wr_bits  = TAG_W'(wr_be) << (wr_word * BE_W);

  dbb_store #(.NUM_BLK(NUM_BLK), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_blk  (ld_blk),
    .ld_data (ld_data),
    .wr_en   (wr_ok),
    .wr_blk  (wr_blk),
    .wr_word (wr_word),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_blk  (rd_blk),
    .rd_word (rd_word),
    .rd_data (rd_data),
    .wb_req  (wb_req),
    .wb_blk  (wb_blk),
    .wb_data (wb_data)
  );

  dbb_tags #(.NUM_BLK(NUM_BLK), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_blk   (ld_blk),
    .set_en   (wr_ok),
    .set_blk  (wr_blk),
    .set_bits (wr_bits),
    .clr_en   (wb_done),
    .clr_blk  (wb_done_blk),
    .rd_en    (wb_req),
    .rd_blk   (wb_blk),
    .rd_mask  (wb_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      collide  <= 1'b0;
    end else begin
      wb_valid <= wb_req;
      collide  <= hit_same;
    end
  end
endmodule

// File: rtl/dbb_checker.sv
module dbb_checker #(
  parameter int BLK_AW = 3,
  parameter int TAG_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_en,
  input logic [BLK_AW-1:0] ld_blk,
  input logic              wr_en,
  input logic [BLK_AW-1:0] wr_blk,
  input logic              wb_req,
  input logic [BLK_AW-1:0] wb_blk,
  input logic              wb_valid,
  input logic [TAG_W-1:0]  wb_mask,
  input logic              collide
);
  // R1: outputs quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!wb_valid && !collide));

  // R6: valid follows a request by one cycle
  a_r6_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    wb_req |=> wb_valid);

  // R6: no valid without a request
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !wb_req |=> !wb_valid);

  // R8: same-block load and write raise the flag
  a_r8_flag_on_collision: assert property (@(posedge clk) disable iff (rst)
    (ld_en && wr_en && ld_blk == wr_blk) |=> collide);

  // R9: no flag otherwise
  a_r9_no_flag_otherwise: assert property (@(posedge clk) disable iff (rst)
    !(ld_en && wr_en && ld_blk == wr_blk) |=> !collide);

  // R2: write-back of a block loaded two cycles earlier shows a clean mask
  a_r2_load_clears_mask: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && $past(ld_en, 2) && $past(ld_blk, 2) == $past(wb_blk))
      |-> (wb_mask == '0));
endmodule

bind dirty_block_buf dbb_checker #(.BLK_AW(BLK_AW), .TAG_W(TAG_W)) u_dbb_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_en    (ld_en),
  .ld_blk   (ld_blk),
  .wr_en    (wr_en),
  .wr_blk   (wr_blk),
  .wb_req   (wb_req),
  .wb_blk   (wb_blk),
  .wb_valid (wb_valid),
  .wb_mask  (wb_mask),
  .collide  (collide)
);

// File: tb/dirty_block_buf_tb_top.sv
module dirty_block_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int NW = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         ld_en;
  logic [2:0]   ld_blk;
  logic [255:0] ld_data;
  logic         wr_en;
  logic [2:0]   wr_blk;
  logic [2:0]   wr_word;
  logic [3:0]   wr_be;
  logic [31:0]  wr_data;
  logic         rd_en;
  logic [2:0]   rd_blk;
  logic [2:0]   rd_word;
  logic [31:0]  rd_data;
  logic         wb_req;
  logic [2:0]   wb_blk;
  logic         wb_valid;
  logic [255:0] wb_data;
  logic [31:0]  wb_mask;
  logic         wb_done;
  logic [2:0]   wb_done_blk;
  logic         collide;

  always #(CLK_PERIOD/2) clk = ~clk;

  dirty_block_buf dut_i (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_blk(ld_blk), .ld_data(ld_data),
    .wr_en(wr_en), .wr_blk(wr_blk), .wr_word(wr_word), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_blk(rd_blk), .rd_word(rd_word), .rd_data(rd_data),
    .wb_req(wb_req), .wb_blk(wb_blk), .wb_valid(wb_valid), .wb_data(wb_data),
    .wb_mask(wb_mask), .wb_done(wb_done), .wb_done_blk(wb_done_blk), .collide(collide)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] m_data [NB][NW];
  logic [31:0] m_tag  [NB];
  bit          m_known[NB];

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] blk_of(input int b);
    logic [255:0] v;
    for (int w = 0; w < NW; w++) v[w*32 +: 32] = m_data[b][w];
    return v;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic idle();
    ld_en = 0; ld_blk = 0; ld_data = '0;
    wr_en = 0; wr_blk = 0; wr_word = 0; wr_be = 0; wr_data = 0;
    rd_en = 0; rd_blk = 0; rd_word = 0;
    wb_req = 0; wb_blk = 0; wb_done = 0; wb_done_blk = 0;
  endtask

  // Inputs already driven; predict, update model, clock, compare.
  task automatic cycle();
    bit          coll, e_rd_v, e_wb_v, e_rd_known, e_wb_known;
    logic [31:0] e_rd, e_mask;
    logic [255:0] e_wb;
    coll = ld_en && wr_en && ld_blk == wr_blk;
    e_rd_v = rd_en;  e_rd = m_data[rd_blk][rd_word]; e_rd_known = m_known[rd_blk];
    e_wb_v = wb_req; e_wb = blk_of(wb_blk); e_mask = m_tag[wb_blk];
    e_wb_known = m_known[wb_blk];
    if (wb_done) m_tag[wb_done_blk] = '0;
    if (wr_en && !coll) begin
      m_data[wr_blk][wr_word] = merge(m_data[wr_blk][wr_word], wr_data, wr_be);
      m_tag[wr_blk] = m_tag[wr_blk] | (32'(wr_be) << (wr_word * 4));
    end
    if (ld_en) begin
      for (int w = 0; w < NW; w++) m_data[ld_blk][w] = ld_data[w*32 +: 32];
      m_tag[ld_blk] = '0;
      m_known[ld_blk] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(collide === coll, coll ? "R8 collide" : "R9 collide", 256'(collide), 256'(coll));
    chk(wb_valid === e_wb_v, "R6 wb_valid", 256'(wb_valid), 256'(e_wb_v));
    if (e_wb_v) begin
      chk(wb_mask === e_mask, "R4 R7 wb_mask", 256'(wb_mask), 256'(e_mask));
      if (e_wb_known) chk(wb_data === e_wb, "R6 wb_data", wb_data, e_wb);
    end
    if (e_rd_v && e_rd_known)
      chk(rd_data === e_rd, "R5 rd_data", 256'(rd_data), 256'(e_rd));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin m_tag[b] = '0; m_known[b] = 0; end
    idle();
    rst = 1;
    // dirty some block during reset: must not survive
    wr_en = 1; wr_be = 4'hF;
    repeat (3) @(negedge clk);
    idle();
    rst = 0;
    chk(wb_valid === 1'b0 && collide === 1'b0, "R1 outputs", 256'({wb_valid, collide}), 256'(0));
    for (int b = 0; b < NB; b++) begin
      wb_req = 1; wb_blk = 3'(b);
      cycle();
    end
    idle();
    // fill all blocks (R2)
    for (int b = 0; b < NB; b++) begin
      ld_en = 1; ld_blk = 3'(b); ld_data = rnd256();
      cycle();
    end
    idle();
    // R3/R4: top word, alternating bytes
    wr_en = 1; wr_blk = 2; wr_word = 7; wr_be = 4'b0101; wr_data = 32'hA1B2C3D4;
    cycle(); idle();
    wb_req = 1; wb_blk = 2; cycle(); idle();
    chk(wb_mask === 32'h5000_0000, "R4 top word mask", 256'(wb_mask), 256'h5000_0000);
    chk(wb_data[231:224] === 8'hD4 && wb_data[247:240] === 8'hB2, "R3 enabled bytes",
        256'(wb_data[255:224]), 256'(m_data[2][7]));
    // R4: OR with existing bits
    wr_en = 1; wr_blk = 2; wr_word = 0; wr_be = 4'b1000; wr_data = 32'h11223344;
    cycle(); idle();
    wb_req = 1; wb_blk = 2; cycle(); idle();
    chk(wb_mask === 32'h5000_0008, "R4 OR accumulate", 256'(wb_mask), 256'h5000_0008);
    // R7: done clears, concurrent write keeps its bits
    wb_done = 1; wb_done_blk = 2; wr_en = 1; wr_blk = 2; wr_word = 1; wr_be = 4'b0011;
    wr_data = 32'hFFFF0000;
    cycle(); idle();
    wb_req = 1; wb_blk = 2; cycle(); idle();
    chk(wb_mask === 32'h0000_0030, "R7 done and write", 256'(wb_mask), 256'h30);
    // R8: same-block collision, write dropped
    ld_en = 1; ld_blk = 4; ld_data = rnd256();
    wr_en = 1; wr_blk = 4; wr_word = 3; wr_be = 4'hF; wr_data = 32'hDEADBEEF;
    cycle(); idle();
    wb_req = 1; wb_blk = 4; cycle(); idle();
    chk(wb_mask === 32'h0 && collide === 1'b0, "R8 write dropped, flag one cycle",
        256'({collide, wb_mask}), 256'(0));
    // R9: different blocks at once
    ld_en = 1; ld_blk = 5; ld_data = rnd256();
    wr_en = 1; wr_blk = 6; wr_word = 2; wr_be = 4'hF; wr_data = 32'h0BADF00D;
    cycle(); idle();
    wb_req = 1; wb_blk = 6; cycle(); idle();
    chk(wb_mask === 32'h0000_0F00, "R9 write to other block", 256'(wb_mask), 256'hF00);
    // R5: read in the write cycle returns old value
    rd_en = 1; rd_blk = 6; rd_word = 2;
    wr_en = 1; wr_blk = 6; wr_word = 2; wr_be = 4'hF; wr_data = 32'h12345678;
    cycle(); idle();
    chk(rd_data === 32'h0BADF00D, "R5 read-first", 256'(rd_data), 256'h0BADF00D);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      ld_en = ($urandom % 6) == 0; ld_blk = 3'($urandom); ld_data = rnd256();
      wr_en = ($urandom % 2) == 0; wr_blk = 3'($urandom); wr_word = 3'($urandom);
      wr_be = 4'($urandom); wr_data = $urandom;
      rd_en = ($urandom % 2) == 0; rd_blk = 3'($urandom); rd_word = 3'($urandom);
      wb_req = ($urandom % 3) == 0; wb_blk = 3'($urandom);
      wb_done = ($urandom % 5) == 0; wb_done_blk = 3'($urandom);
      cycle();
    end
    idle();
    cycle();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule